// File: doc/BRIEF.md
# Conditional Jump Evaluator

This block resolves the relative-jump instruction class of a 16-bit processor. Each cycle it takes an instruction word, the byte address of that word and the four status flags: overflow, negative, zero and carry. It registers two results: whether the jump is taken and the target address. A taken jump lands a whole number of 16-bit words away from the word that follows the jump. The reach is 512 words back and 511 words forward.

The word is a jump only when its top three bits hold the jump opcode. Any other word never reports a jump as taken, whatever its lower bits hold. There are eight conditions. Two of them are signed comparisons. They look at negative XOR overflow, so they give the right answer after an arithmetic overflow. The block only reads the flags and never drives them. The fetch unit uses the registered outputs one cycle later to redirect the program counter.

Top module: `jcc_eval`

## Requirements
- R1: A word is a jump only when bits 15:13 equal 3'b001. For every other value of those bits, taken_o is 0, whatever the condition field and flags are.
- R2: The condition field is bits 12:10. Code 3'b000 is taken when Z=0, and code 3'b001 is taken when Z=1.
- R3: Code 3'b010 is taken when C=0, and code 3'b011 is taken when C=1.
- R4: Code 3'b100 is taken when N=1.
- R5: Code 3'b101 is taken when (N XOR V)=0, and code 3'b110 is taken when (N XOR V)=1.
- R6: Code 3'b111 is always taken.
- R7: target_o equals pc + 2 + 2*s modulo 65536. Here s is bits 9:0 read as a two's-complement number in the range -512..+511.
- R8: Both outputs are registered. They show the inputs sampled at the previous rising clock edge and do not change between edges.
- R9: While rst_ni is low, taken_o is 0 and target_o is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Byte address of the instruction word |
| flag_v_i | input | 1 | Overflow flag |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| taken_o | output | 1 | Jump taken, registered |
| target_o | output | 16 | Jump target byte address, registered |

## Verification
Two results can meet in one cycle:
- the opcode gate against a condition that would otherwise be true;
- the taken decision against a target that wraps past either end of the 64K space.

The bench provokes the first by sweeping every non-jump opcode with every condition code and every flag combination. Code 3'b111 is included, and taken_o must still stay low. It provokes the second by sweeping all 1024 offsets from program counters near 0x0000 and near 0xFFFE while the condition is always-taken. Each case checks taken_o and the target computed modulo 65536 in the same sample.

// File: rtl/jcc_pkg.sv
package jcc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 3;
  localparam int unsigned COND_W = 3;
  localparam int unsigned OFF_W  = 10;
  localparam logic [OPC_W-1:0] JUMP_OPC = 3'b001;

  typedef enum logic [COND_W-1:0] {
    CC_NE  = 3'b000,
    CC_EQ  = 3'b001,
    CC_NC  = 3'b010,
    CC_CS  = 3'b011,
    CC_NEG = 3'b100,
    CC_GE  = 3'b101,
    CC_LT  = 3'b110,
    CC_ALW = 3'b111
  } cond_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/jcc_decode.sv
module jcc_decode
  import jcc_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned OW   = OFF_W,
  parameter int unsigned CW   = COND_W,
  parameter int unsigned PW   = OPC_W
) (
  input  logic [W-1:0]  instr_i,
  output logic          is_jump_o,
  output cond_e         cond_o,
  output logic [OW-1:0] offset_o
);
  localparam int unsigned OPC_LSB  = W - PW;
  localparam int unsigned COND_LSB = OW;

  assign is_jump_o = (instr_i[W-1:OPC_LSB] == JUMP_OPC);
  assign cond_o    = cond_e'(instr_i[COND_LSB+CW-1:COND_LSB]);
  assign offset_o  = instr_i[OW-1:0];
endmodule

// File: rtl/jcc_cond_eval.sv
module jcc_cond_eval
  import jcc_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   hit_o
);
  logic lt_signed;
  assign lt_signed = flags_i.n ^ flags_i.v;  // stays correct across overflow

  always_comb begin
    unique case (cond_i)
      CC_NE:   hit_o = ~flags_i.z;
      CC_EQ:   hit_o =  flags_i.z;
      CC_NC:   hit_o = ~flags_i.c;
      CC_CS:   hit_o =  flags_i.c;
      CC_NEG:  hit_o =  flags_i.n;
      CC_GE:   hit_o = ~lt_signed;
      CC_LT:   hit_o =  lt_signed;
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/jcc_target_calc.sv
module jcc_target_calc #(
  parameter int unsigned W  = 16,
  parameter int unsigned OW = 10
) (
  input  logic [W-1:0]  pc_i,
  input  logic [OW-1:0] offset_i,
  output logic [W-1:0]  target_o
);
  localparam int unsigned EXT_W = W - OW - 1;

  logic [W-1:0] byte_disp;
  logic [W-1:0] next_pc;

  // sign extend, then scale words to bytes
  assign byte_disp = {{EXT_W{offset_i[OW-1]}}, offset_i, 1'b0};
  assign next_pc   = pc_i + W'(2);
  assign target_o  = next_pc + byte_disp;  // wraps modulo 2**W
endmodule

// File: rtl/jcc_eval.sv
module jcc_eval
  import jcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic              flag_v_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  output logic              taken_o,
  output logic [WORD_W-1:0] target_o
);
  localparam int unsigned OPC_LSB  = WORD_W - OPC_W;
  localparam int unsigned COND_LSB = OFF_W;

  logic             is_jump;
  cond_e            cond;
  logic [OFF_W-1:0] offset;
  logic             cond_hit;
  logic [WORD_W-1:0] target_d;
  flags_t           flags;
  logic             armed_q;

  assign flags = '{v: flag_v_i, n: flag_n_i, z: flag_z_i, c: flag_c_i};

  jcc_decode #(.W(WORD_W), .OW(OFF_W), .CW(COND_W), .PW(OPC_W)) u_decode (
    .instr_i  (instr_i),
    .is_jump_o(is_jump),
    .cond_o   (cond),
    .offset_o (offset)
  );

  jcc_cond_eval u_cond (
    .cond_i (cond),
    .flags_i(flags),
    .hit_o  (cond_hit)
  );

  jcc_target_calc #(.W(WORD_W), .OW(OFF_W)) u_target (
    .pc_i    (pc_i),
    .offset_i(offset),
    .target_o(target_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o  <= 1'b0;
      target_o <= '0;
      armed_q  <= 1'b0;
    end else begin
      taken_o  <= is_jump & cond_hit;
      target_o <= target_d;
      armed_q  <= 1'b1;
    end
  end

  // armed_q marks that $past samples come from after reset
  p_format_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && taken_o) |-> ($past(instr_i[WORD_W-1:OPC_LSB]) == JUMP_OPC));

  p_eq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(instr_i[WORD_W-1:COND_LSB]) == {JUMP_OPC, CC_EQ})
      |-> (taken_o == $past(flag_z_i)));

  p_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(instr_i[WORD_W-1:COND_LSB]) == {JUMP_OPC, CC_NC})
      |-> (taken_o == !$past(flag_c_i)));

  p_signed_lt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(instr_i[WORD_W-1:COND_LSB]) == {JUMP_OPC, CC_LT})
      |-> (taken_o == ($past(flag_n_i) ^ $past(flag_v_i))));

  p_always_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(instr_i[WORD_W-1:COND_LSB]) == {JUMP_OPC, CC_ALW})
      |-> taken_o);

  p_parity_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (target_o[0] == $past(pc_i[0])));
endmodule

// File: tb/jcc_eval_tb.sv
`timescale 1ns/1ps
module jcc_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc = '0;
  logic        fv = 1'b0, fn = 1'b0, fz = 1'b0, fc = 1'b0;
  logic        taken;
  logic [15:0] target;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  jcc_eval u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .pc_i(pc),
    .flag_v_i(fv), .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc),
    .taken_o(taken), .target_o(target)
  );

  function automatic bit exp_taken(input int op, input int cc, input bit v, input bit n,
                                   input bit z, input bit c);
    bit h;
    if (op != 1) return 1'b0;
    case (cc)
      0: h = !z;        // R2 NE
      1: h = z;         // R2 EQ
      2: h = !c;        // R3 NC
      3: h = c;         // R3 C
      4: h = n;         // R4
      5: h = (n == v);  // R5 GE
      6: h = (n != v);  // R5 LT
      default: h = 1'b1; // R6
    endcase
    return h;
  endfunction

  function automatic logic [15:0] exp_target(input int p, input int off);
    int s;
    s = (off >= 512) ? off - 1024 : off;
    return 16'((p + 2 + 2 * s + 131072) % 65536);
  endfunction

  task automatic chk1(input string req, input logic act, input logic expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s taken act=%0b exp=%0b", req, act, expv);
    end
  endtask

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s target act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic apply(input int op, input int cc, input int off, input int p, input int fl);
    @(negedge clk);
    instr = {3'(op), 3'(cc), 10'(off)};
    pc = 16'(p);
    {fv, fn, fz, fc} = 4'(fl);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    instr = 16'h3C05;
    pc = 16'h1234;
    repeat (3) @(negedge clk);
    chk1("R9", taken, 1'b0);
    chk16("R9", target, 16'h0000);
    rst_n = 1'b1;

    // R2..R6: every condition x every flag set, several offsets
    for (int cc = 0; cc < 8; cc++)
      for (int fl = 0; fl < 16; fl++)
        for (int k = 0; k < 3; k++) begin
          int off;
          off = (k == 0) ? 0 : (k == 1) ? 511 : 512;
          apply(1, cc, off, 16'h8000 + 4 * fl, fl);
          chk1(cc < 2 ? "R2" : cc < 4 ? "R3" : cc == 4 ? "R4" : cc < 7 ? "R5" : "R6",
               taken, exp_taken(1, cc, fl[3], fl[2], fl[1], fl[0]));
          chk16("R7", target, exp_target(16'h8000 + 4 * fl, off));
        end

    // R1: opcode gate, even for always-taken code
    for (int op = 0; op < 8; op++)
      if (op != 1)
        for (int cc = 0; cc < 8; cc++)
          for (int fl = 0; fl < 16; fl++) begin
            apply(op, cc, 37, 16'h0100, fl);
            chk1("R1", taken, 1'b0);
          end

    // R7: full offset sweep incl. wrap at both ends, taken at the same time
    for (int pi = 0; pi < 4; pi++)
      for (int off = 0; off < 1024; off++) begin
        int p;
        p = (pi == 0) ? 0 : (pi == 1) ? 16'hFFFE : (pi == 2) ? 16'h0200 : 16'h7FF1;
        apply(1, 7, off, p, 0);
        chk1("R7", taken, 1'b1);
        chk16("R7", target, exp_target(p, off));
      end

    // R8: output holds until the next rising edge
    apply(1, 7, 5, 16'h4000, 0);
    @(negedge clk);
    instr = 16'h0000;
    pc = 16'h2000;
    #1;
    chk1("R8", taken, 1'b1);
    chk16("R8", target, 16'h400C);
    @(negedge clk);
    chk1("R8", taken, 1'b0);
    chk16("R8", target, 16'h2002);

    // R9: reset mid-run clears outputs
    apply(1, 7, 5, 16'h4000, 0);
    rst_n = 1'b0;
    #1;
    chk1("R9", taken, 1'b0);
    chk16("R9", target, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule